// File: doc/BRIEF.md
# Two-Byte Configuration Register Target on a Two-Wire Serial Bus

This block is a target device on a two-wire serial bus (I2C, standard mode). It holds two configuration bytes that set up a pair of on-chip frequency synthesizers. The block samples the bus lines with the system clock. It pulls SDA low through an output enable and never drives it high. Two control outputs are decoded from the stored bytes.

A write transaction names a starting byte index, then a byte count, then the data bytes. A read transaction names the index in a write phase, then issues a repeated start and the read address. The target first returns how many bytes are available from that index, then the bytes themselves. The host acknowledges every byte it wants and ends the read with a not-acknowledge. The system clock must run many times faster than SCL; the bus lines pass through two synchronizing flops before any decision.

Top module: `cfg_i2c_target`

## Requirements
- R1: After reset, byte 0 holds 0x6F and byte 1 holds 0x3F, so `syn2_en` is 1 and `sel48` is 0, and `sda_oe` is 0.
- R2: The target acknowledges the 7-bit address 0x6A (0xD4 to write, 0xD5 to read). For any other address it gives no acknowledge and keeps SDA released until the next start condition. A stop condition releases SDA.
- R3: In a write, the index byte, the count byte and each data byte are acknowledged. Data byte k lands in register index+k, and each write takes effect at the falling SCL edge that ends that byte.
- R4: A data byte is acknowledged but discarded when the declared count is already used up or when its index is 2 or higher.
- R5: A read after a repeated start first returns the count of available bytes: 2 minus the index, or 0 when the index is 2 or higher. The register bytes follow from the index upward, and every byte past the last register reads 0xFF.
- R6: A not-acknowledge from the host after a read byte makes the target release SDA and stay silent for the rest of the transfer.
- R7: `syn2_en` equals byte 0 bit 1. `sel48` equals byte 1 bit 7, where 1 selects 48 MHz and 0 selects 72 MHz. Byte 0 bit 0 is stored and read back but changes no output. Registers change only on a write.
- R8: The target begins to pull SDA low only while SCL is low.
- R9: A start condition at any point, including in the middle of a byte, clears the bit count and restarts address reception.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, many times the SCL rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Serial clock line as seen at the pad |
| sda_i | input | 1 | Serial data line as seen at the pad |
| sda_oe | output | 1 | 1 pulls SDA low; 0 releases it |
| syn2_en | output | 1 | Enable for the secondary synthesizer |
| sel48 | output | 1 | Secondary output select: 1 for 48 MHz, 0 for 72 MHz |

## Verification
The assertions watch the rules that hold at every cycle:
- SDA is only pulled low while the synchronized SCL is low.
- SDA is released after any start or stop.
- Register writes happen only at a byte-ending SCL fall and only in range.
- Register contents hold whenever no write is issued.

The byte-level protocol needs the bench's scenarios. These cover address match and mismatch, count clamping on writes and reads, the 0xFF fill past the last register, the not-acknowledge path and restart mid-byte. They show that the right value reaches the right register and comes back in the right order.

// File: rtl/cfg_i2c_pkg.sv
package cfg_i2c_pkg;
  typedef logic [7:0] byte_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RX,
    ST_ACK,
    ST_TX,
    ST_MACK,
    ST_TXNEXT
  } st_e;

  typedef enum logic [1:0] {
    K_ADDR,
    K_IDX,
    K_CNT,
    K_DATA
  } kind_e;
endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_hi,
  output logic sda_hi,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  localparam int W = SYNC_STAGES + 1;

  logic [W-1:0] scl_q, scl_d;
  logic [W-1:0] sda_q, sda_d;
  logic scl_prev, sda_prev;

  always_comb begin
    scl_d = {scl_q[W-2:0], scl_i};
    sda_d = {sda_q[W-2:0], sda_i};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= '1;
      sda_q <= '1;
    end else begin
      scl_q <= scl_d;
      sda_q <= sda_d;
    end
  end

  assign scl_hi    = scl_q[W-2];
  assign sda_hi    = sda_q[W-2];
  assign scl_prev  = scl_q[W-1];
  assign sda_prev  = sda_q[W-1];
  assign scl_rise  = scl_hi & ~scl_prev;
  assign scl_fall  = ~scl_hi & scl_prev;
  assign start_det = scl_hi & scl_prev & sda_prev & ~sda_hi;
  assign stop_det  = scl_hi & scl_prev & ~sda_prev & sda_hi;
endmodule

// File: rtl/cfg_regs.sv
module cfg_regs #(
  parameter int NUM_REGS = 2,
  parameter logic [NUM_REGS-1:0][7:0] RST_VAL = {8'h3F, 8'h6F}
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wr_en,
  input  logic [7:0]                 wr_idx,
  input  logic [7:0]                 wr_data,
  output logic [NUM_REGS-1:0][7:0]   regs
);
  logic [NUM_REGS-1:0][7:0] regs_q, regs_d;

  always_comb begin
    regs_d = regs_q;
    for (int i = 0; i < NUM_REGS; i++) begin
      if (wr_en && (wr_idx == 8'(i))) regs_d[i] = wr_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) regs_q <= RST_VAL;
    else        regs_q <= regs_d;
  end

  assign regs = regs_q;
endmodule

// File: rtl/i2c_xfer_fsm.sv
module i2c_xfer_fsm
  import cfg_i2c_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h6A,
  parameter int         NUM_REGS = 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     scl_rise,
  input  logic                     scl_fall,
  input  logic                     sda_hi,
  input  logic                     start_det,
  input  logic                     stop_det,
  input  logic [NUM_REGS-1:0][7:0] regs,
  output logic                     wr_en,
  output logic [7:0]               wr_idx,
  output logic [7:0]               wr_data,
  output logic                     sda_oe
);
  localparam int    IW    = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1;
  localparam byte_t NREGS = 8'(NUM_REGS);

  st_e   st_q, st_d;
  kind_e kind_q, kind_d;
  logic [3:0] bit_q, bit_d;
  byte_t sh_q, sh_d, ptr_q, ptr_d, left_q, left_d, tx_q, tx_d;
  logic  rw_q, rw_d, oe_q, oe_d;
  logic  in_range;
  byte_t rd_byte, avail;

  assign in_range = (ptr_q < NREGS);
  assign rd_byte  = in_range ? regs[ptr_q[IW-1:0]] : 8'hFF;
  assign avail    = in_range ? (NREGS - ptr_q) : 8'h00;

  always_comb begin
    st_d    = st_q;
    kind_d  = kind_q;
    bit_d   = bit_q;
    sh_d    = sh_q;
    ptr_d   = ptr_q;
    left_d  = left_q;
    tx_d    = tx_q;
    rw_d    = rw_q;
    wr_en   = 1'b0;
    wr_idx  = ptr_q;
    wr_data = sh_q;
    if (start_det) begin
      st_d   = ST_RX;
      kind_d = K_ADDR;
      bit_d  = 4'd0;
    end else if (stop_det) begin
      st_d = ST_IDLE;
    end else begin
      unique case (st_q)
        ST_RX: begin
          if (scl_rise && (bit_q < 4'd8)) begin
            sh_d  = {sh_q[6:0], sda_hi};
            bit_d = 4'(bit_q + 4'd1);
          end else if (scl_fall && (bit_q == 4'd8)) begin
            st_d = ST_ACK;
            unique case (kind_q)
              K_ADDR: begin
                if (sh_q[7:1] == DEV_ADDR) rw_d = sh_q[0];
                else                       st_d = ST_IDLE;
              end
              K_IDX: ptr_d  = sh_q;
              K_CNT: left_d = sh_q;
              K_DATA: begin
                if (left_q != 8'h00) begin
                  left_d = 8'(left_q - 8'h01);
                  if (in_range) begin
                    wr_en = 1'b1;
                    ptr_d = 8'(ptr_q + 8'h01);
                  end
                end
              end
              default: ;
            endcase
          end
        end
        ST_ACK: begin
          if (scl_fall) begin
            bit_d = 4'd0;
            if ((kind_q == K_ADDR) && rw_q) begin
              tx_d = avail;
              st_d = ST_TX;
            end else begin
              st_d = ST_RX;
              unique case (kind_q)
                K_ADDR:  kind_d = K_IDX;
                K_IDX:   kind_d = K_CNT;
                default: kind_d = K_DATA;
              endcase
            end
          end
        end
        ST_TX: begin
          if (scl_fall) begin
            if (bit_q == 4'd7) begin
              st_d  = ST_MACK;
              bit_d = 4'd0;
            end else begin
              tx_d  = {tx_q[6:0], 1'b1};
              bit_d = 4'(bit_q + 4'd1);
            end
          end
        end
        ST_MACK: begin
          if (scl_rise) st_d = sda_hi ? ST_IDLE : ST_TXNEXT;
        end
        ST_TXNEXT: begin
          if (scl_fall) begin
            tx_d  = rd_byte;
            bit_d = 4'd0;
            st_d  = ST_TX;
            if (in_range) ptr_d = 8'(ptr_q + 8'h01);
          end
        end
        default: ;
      endcase
    end
    oe_d = (st_d == ST_ACK) || ((st_d == ST_TX) && !tx_d[7]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      kind_q <= K_ADDR;
      bit_q  <= 4'd0;
      sh_q   <= 8'h00;
      ptr_q  <= 8'h00;
      left_q <= 8'h00;
      tx_q   <= 8'hFF;
      rw_q   <= 1'b0;
      oe_q   <= 1'b0;
    end else begin
      st_q   <= st_d;
      kind_q <= kind_d;
      bit_q  <= bit_d;
      sh_q   <= sh_d;
      ptr_q  <= ptr_d;
      left_q <= left_d;
      tx_q   <= tx_d;
      rw_q   <= rw_d;
      oe_q   <= oe_d;
    end
  end

  assign sda_oe = oe_q;
endmodule

// File: rtl/cfg_i2c_target.sv
module cfg_i2c_target #(
  parameter logic [6:0]               DEV_ADDR    = 7'h6A,
  parameter int                       NUM_REGS    = 2,
  parameter logic [NUM_REGS-1:0][7:0] RST_VAL     = {8'h3F, 8'h6F},
  parameter int                       SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_oe,
  output logic syn2_en,
  output logic sel48
);
  logic [1:0] rst_pipe;
  logic       rst_int_n;
  logic       scl_hi, sda_hi, scl_rise, scl_fall, start_det, stop_det;
  logic       wr_en;
  logic [7:0] wr_idx, wr_data;
  logic [NUM_REGS-1:0][7:0] regs;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_int_n = rst_pipe[1];

  i2c_line_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_int_n), .scl_i(scl_i), .sda_i(sda_i),
    .scl_hi(scl_hi), .sda_hi(sda_hi), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  i2c_xfer_fsm #(.DEV_ADDR(DEV_ADDR), .NUM_REGS(NUM_REGS)) u_fsm (
    .clk(clk), .rst_n(rst_int_n), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .sda_hi(sda_hi), .start_det(start_det), .stop_det(stop_det), .regs(regs),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data), .sda_oe(sda_oe)
  );

  cfg_regs #(.NUM_REGS(NUM_REGS), .RST_VAL(RST_VAL)) u_regs (
    .clk(clk), .rst_n(rst_int_n), .wr_en(wr_en), .wr_idx(wr_idx),
    .wr_data(wr_data), .regs(regs)
  );

  assign syn2_en = regs[0][1];
  assign sel48   = regs[1][7];
endmodule

// File: rtl/cfg_i2c_target_chk.sv
module cfg_i2c_target_chk #(
  parameter int NUM_REGS = 2
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     scl_hi,
  input logic                     scl_fall,
  input logic                     start_det,
  input logic                     stop_det,
  input logic                     wr_en,
  input logic [7:0]               wr_idx,
  input logic [NUM_REGS-1:0][7:0] regs,
  input logic                     sda_oe
);
  a_r8_oe_rise_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> !scl_hi);

  a_r9_start_releases: assert property (@(posedge clk) disable iff (!rst_n)
    start_det |=> !sda_oe);

  a_r2_stop_releases: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> !sda_oe);

  a_r4_write_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (wr_idx < 8'(NUM_REGS)));

  a_r3_write_at_byte_end: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> scl_fall);

  a_r7_regs_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(regs));
endmodule

bind cfg_i2c_target cfg_i2c_target_chk #(.NUM_REGS(NUM_REGS)) u_chk (
  .clk(clk), .rst_n(rst_int_n), .scl_hi(scl_hi), .scl_fall(scl_fall),
  .start_det(start_det), .stop_det(stop_det), .wr_en(wr_en), .wr_idx(wr_idx),
  .regs(regs), .sda_oe(sda_oe)
);

// File: tb/cfg_i2c_target_tb_top.sv
module cfg_i2c_target_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic m_scl = 1'b1;
  logic m_sda = 1'b1;
  logic sda_line, sda_oe, syn2_en, sel48;
  int   checks = 0;
  int   failures = 0;
  int   oe_viol = 0;
  logic prev_oe = 1'b0;
  logic done = 1'b0;
  logic [7:0] rd_buf [0:3];

  always #10 clk = ~clk;

  assign sda_line = m_sda & ~sda_oe;

  cfg_i2c_target dut_i (
    .clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(sda_line),
    .sda_oe(sda_oe), .syn2_en(syn2_en), .sel48(sel48)
  );

  // R8: SDA pull-down must never begin while SCL is high
  always @(negedge clk) begin
    if (sda_oe && !prev_oe && m_scl) oe_viol++;
    prev_oe <= sda_oe;
  end

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic q();
    repeat (10) @(negedge clk);
  endtask

  task automatic bus_start();
    m_sda = 1'b1; q();
    m_scl = 1'b1; q();
    m_sda = 1'b0; q();
    m_scl = 1'b0; q();
  endtask

  task automatic bus_stop();
    m_sda = 1'b0; q();
    m_scl = 1'b1; q();
    m_sda = 1'b1; q();
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      m_sda = b[i]; q();
      m_scl = 1'b1; q(); q();
      m_scl = 1'b0; q();
    end
    m_sda = 1'b1; q();
    m_scl = 1'b1; q();
    ack = ~sda_line; q();
    m_scl = 1'b0; q();
  endtask

  task automatic recv_byte(input logic give_ack, output logic [7:0] b);
    m_sda = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      q();
      m_scl = 1'b1; q();
      b[i] = sda_line; q();
      m_scl = 1'b0;
    end
    m_sda = ~give_ack; q();
    m_scl = 1'b1; q(); q();
    m_scl = 1'b0; q();
    m_sda = 1'b1;
  endtask

  task automatic do_write(input logic [7:0] idx, input logic [7:0] cnt, input int n,
                          input logic [7:0] d0, input logic [7:0] d1,
                          input logic [7:0] d2, input string tag);
    logic ack;
    logic [7:0] d [0:2];
    d[0] = d0; d[1] = d1; d[2] = d2;
    bus_start();
    send_byte(8'hD4, ack); check({tag, " addr ack"}, ack, 1);
    send_byte(idx, ack);   check({tag, " idx ack"}, ack, 1);
    send_byte(cnt, ack);   check({tag, " cnt ack"}, ack, 1);
    for (int i = 0; i < n; i++) begin
      send_byte(d[i], ack); check({tag, " data ack"}, ack, 1);
    end
    bus_stop();
  endtask

  // read: count byte then n data bytes, last byte not acknowledged
  task automatic do_read(input logic [7:0] idx, input int n, input string tag);
    logic ack;
    logic [7:0] b;
    bus_start();
    send_byte(8'hD4, ack); check({tag, " waddr ack"}, ack, 1);
    send_byte(idx, ack);   check({tag, " idx ack"}, ack, 1);
    bus_start();
    send_byte(8'hD5, ack); check({tag, " raddr ack"}, ack, 1);
    recv_byte(n > 0, b); rd_buf[0] = b;
    for (int i = 1; i <= n; i++) begin
      recv_byte(i < n, b); rd_buf[i] = b;
    end
    bus_stop();
  endtask

  task automatic t_reset();
    check("R1 sda_oe", sda_oe, 0);
    check("R1 syn2_en", syn2_en, 1);
    check("R1 sel48", sel48, 0);
    do_read(8'h00, 2, "R5 reset read");
    check("R5 count idx0", rd_buf[0], 2);
    check("R1 byte0 default", rd_buf[1], 8'h6F);
    check("R1 byte1 default", rd_buf[2], 8'h3F);
  endtask

  task automatic t_write_both();
    do_write(8'h00, 8'h02, 2, 8'h55, 8'hBF, 8'h00, "R3 write both");
    check("R7 syn2_en off", syn2_en, 0);
    check("R7 sel48 48MHz", sel48, 1);
    do_read(8'h00, 2, "R3 readback");
    check("R3 byte0", rd_buf[1], 8'h55);
    check("R3 byte1", rd_buf[2], 8'hBF);
  endtask

  task automatic t_write_one();
    do_write(8'h01, 8'h01, 1, 8'h3F, 8'h00, 8'h00, "R3 write idx1");
    check("R7 sel48 72MHz", sel48, 0);
    check("R3 byte0 untouched", syn2_en, 0);
  endtask

  task automatic t_overflow();
    do_write(8'h01, 8'h02, 2, 8'hAA, 8'h11, 8'h00, "R4 past end");
    do_write(8'h00, 8'h01, 2, 8'h6F, 8'h00, 8'h00, "R4 past count");
    do_read(8'h00, 2, "R4 readback");
    check("R4 byte0 one write", rd_buf[1], 8'h6F);
    check("R4 byte1 extra dropped", rd_buf[2], 8'hAA);
    check("R7 sel48 from AA", sel48, 1);
  endtask

  task automatic t_out_range();
    do_write(8'h05, 8'h01, 1, 8'h00, 8'h00, 8'h00, "R4 bad index");
    check("R4 syn2_en kept", syn2_en, 1);
    check("R4 sel48 kept", sel48, 1);
    do_read(8'h05, 1, "R5 bad index read");
    check("R5 count zero", rd_buf[0], 0);
    check("R5 fill FF", rd_buf[1], 8'hFF);
  endtask

  task automatic t_read_idx1();
    do_read(8'h01, 2, "R5 idx1 read");
    check("R5 count idx1", rd_buf[0], 1);
    check("R5 byte1 first", rd_buf[1], 8'hAA);
    check("R5 past last FF", rd_buf[2], 8'hFF);
  endtask

  task automatic t_bad_addr();
    logic ack;
    bus_start();
    send_byte(8'hA4, ack); check("R2 foreign addr nack", ack, 0);
    send_byte(8'h00, ack); check("R2 silent after mismatch", ack, 0);
    send_byte(8'h00, ack); check("R2 still silent", ack, 0);
    bus_stop();
    check("R2 sel48 kept", sel48, 1);
    check("R2 sda released", sda_oe, 0);
  endtask

  task automatic t_nack();
    logic ack;
    logic [7:0] b;
    bus_start();
    send_byte(8'hD4, ack); check("R6 waddr ack", ack, 1);
    send_byte(8'h00, ack); check("R6 idx ack", ack, 1);
    bus_start();
    send_byte(8'hD5, ack); check("R6 raddr ack", ack, 1);
    recv_byte(1'b0, b);    check("R6 count", b, 2);
    recv_byte(1'b0, b);    check("R6 target silent after nack", b, 8'hFF);
    check("R6 sda released", sda_oe, 0);
    bus_stop();
  endtask

  task automatic t_bit0();
    do_write(8'h00, 8'h01, 1, 8'h6E, 8'h00, 8'h00, "R7 bit0 clear");
    check("R7 syn2_en bit1 set", syn2_en, 1);
    check("R7 sel48 unaffected", sel48, 1);
    do_read(8'h00, 1, "R7 bit0 readback");
    check("R7 bit0 stored", rd_buf[1], 8'h6E);
  endtask

  task automatic t_abort();
    logic ack;
    bus_start();
    for (int i = 0; i < 4; i++) begin
      m_sda = 1'b1; q();
      m_scl = 1'b1; q(); q();
      m_scl = 1'b0; q();
    end
    bus_start();  // R9 restart mid-byte
    send_byte(8'hD4, ack); check("R9 addr after restart", ack, 1);
    send_byte(8'h01, ack); check("R9 idx ack", ack, 1);
    send_byte(8'h01, ack); check("R9 cnt ack", ack, 1);
    send_byte(8'h3F, ack); check("R9 data ack", ack, 1);
    bus_stop();
    check("R9 write landed", sel48, 0);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    t_reset();
    t_write_both();
    t_write_one();
    t_overflow();
    t_out_range();
    t_read_idx1();
    t_bad_addr();
    t_nack();
    t_bit0();
    t_abort();
    check("R8 oe rise with scl low", oe_viol, 0);
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      failures++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule